// File: doc/BRIEF.md
# Flag-Masked Program Counter and Control-Transfer Unit

This block holds the 16-bit program counter of a small processor and decides every control transfer. A controller pulses a strobe each time it fetches an opcode word or the immediate word that follows it. Each strobe moves the PC forward by two bytes. When the controller presents a transfer command, the block evaluates a condition against the three status flags and, if the condition holds, loads a new PC.

The condition is a masked equality: the flags ANDed with a care mask taken from the opcode must equal a polarity field from the same opcode. An all-zero mask with all-zero polarity is an unconditional transfer. A single mask bit tests one flag for set or clear, and several mask bits test combinations. The targets are an absolute immediate (jump), the PC plus the immediate (branch), or a popped address (return). Calls are unconditional and expose the current PC as the return address to be stacked. Stack pointer arithmetic and memory traffic belong to the surrounding controller.

Top module: `pc_flow_unit`

## Requirements
- R1: While rst_ni is low, pc_o is 0x0000; reset is asynchronous.
- R2: With cmd_i = 0, each of fetch_op_i and fetch_imm_i that is high adds 2 to pc_o at the next rising edge, so both together add 4. Addition wraps modulo 2^16.
- R3: The condition holds when (flags_i & op_i[5:3]) == op_i[2:0], where flags_i bit 2 is carry, bit 1 is zero and bit 0 is negative. For a jump or a branch, taken_o shows this condition in the same cycle.
- R4: cmd_i = 1 (jump) with the condition true loads imm_i into pc_o at the next edge.
- R5: cmd_i = 2 (branch) with the condition true loads pc_o + imm_i, modulo 2^16, at the next edge.
- R6: A jump or a branch whose condition is false leaves pc_o unchanged at the next edge.
- R7: cmd_i = 3 (call-jump) and cmd_i = 4 (call-branch) ignore the flags and set taken_o to 1. They load imm_i or pc_o + imm_i respectively. In every cycle, ret_addr_o equals the current pc_o.
- R8: cmd_i = 5 (return) sets taken_o to 1 and loads pop_i into pc_o at the next edge.
- R9: While cmd_i is 1 to 5, the fetch strobes have no effect on pc_o.
- R10: cmd_i values 0, 6 and 7 mean no transfer: taken_o is 0 and the fetch strobes advance the PC as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_op_i | input | 1 | Opcode word fetched this cycle |
| fetch_imm_i | input | 1 | Immediate word fetched this cycle |
| cmd_i | input | 3 | Transfer command: 0 none, 1 jump, 2 branch, 3 call-jump, 4 call-branch, 5 return |
| op_i | input | 16 | Current opcode; bits 5:3 are the care mask and bits 2:0 the polarity |
| imm_i | input | 16 | Immediate target or displacement |
| flags_i | input | 3 | Status flags {carry, zero, negative} |
| pop_i | input | 16 | Return address popped from the stack |
| pc_o | output | 16 | Program counter |
| ret_addr_o | output | 16 | Address to push on a call |
| taken_o | output | 1 | Transfer decision for the present command |

## Verification
taken_o and ret_addr_o are combinational, so they are due in the same cycle as the command. pc_o is registered and takes its new value one edge after the command or strobe. The bench applies each stimulus just after a falling edge and checks the combinational outputs a few nanoseconds later. It then waits for the next falling edge, after exactly one rising edge, to compare pc_o with the reference model. Reset is also released and asserted between edges, so the asynchronous clear is seen before any clock.

// File: rtl/pc_unit_pkg.sv
package pc_unit_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned FLAG_W = 3;

  typedef enum logic [2:0] {
    CMD_NONE        = 3'd0,
    CMD_JUMP        = 3'd1,
    CMD_BRANCH      = 3'd2,
    CMD_CALL_JUMP   = 3'd3,
    CMD_CALL_BRANCH = 3'd4,
    CMD_RETURN      = 3'd5
  } pc_cmd_e;
endpackage

// File: rtl/pc_cond_eval.sv
module pc_cond_eval #(
  parameter int unsigned FLAG_W = 3
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] care_i,
  input  logic [FLAG_W-1:0] pol_i,
  output logic              match_o
);
  logic [FLAG_W-1:0] bit_ok;

  for (genvar g = 0; g < FLAG_W; g++) begin : g_bit
    assign bit_ok[g] = ((flags_i[g] & care_i[g]) == pol_i[g]);
  end

  assign match_o = &bit_ok;
endmodule

// File: rtl/pc_target_gen.sv
module pc_target_gen
  import pc_unit_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [2:0]        cmd_i,
  input  logic              match_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [ADDR_W-1:0] pop_i,
  output logic              active_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o
);
  logic [ADDR_W-1:0] rel_sum;
  assign rel_sum = pc_i + imm_i;

  always_comb begin
    active_o = 1'b1;
    taken_o  = 1'b0;
    target_o = imm_i;
    unique case (cmd_i)
      CMD_JUMP:        begin taken_o = match_i; target_o = imm_i;   end
      CMD_BRANCH:      begin taken_o = match_i; target_o = rel_sum; end
      CMD_CALL_JUMP:   begin taken_o = 1'b1;    target_o = imm_i;   end
      CMD_CALL_BRANCH: begin taken_o = 1'b1;    target_o = rel_sum; end
      CMD_RETURN:      begin taken_o = 1'b1;    target_o = pop_i;   end
      default:         active_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pc_reg.sv
module pc_reg #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned STEP     = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              hold_i,
  input  logic              adv_op_i,
  input  logic              adv_imm_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] adv;
  assign adv = (adv_op_i ? STEP_V : '0) + (adv_imm_i ? STEP_V : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_o <= RESET_PC;
    else if (load_i) pc_o <= target_i;
    else if (!hold_i) pc_o <= pc_o + adv;
  end
endmodule

// File: rtl/pc_flow_unit.sv
module pc_flow_unit
  import pc_unit_pkg::*;
#(
  parameter int unsigned OP_W     = 16,
  parameter int unsigned CARE_LSB = 3,
  parameter int unsigned POL_LSB  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_op_i,
  input  logic              fetch_imm_i,
  input  logic [2:0]        cmd_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [ADDR_W-1:0] pop_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic              taken_o
);
  logic              match;
  logic              active;
  logic              taken;
  logic [ADDR_W-1:0] target;

  pc_cond_eval #(.FLAG_W(FLAG_W)) u_cond (
    .flags_i (flags_i),
    .care_i  (op_i[CARE_LSB +: FLAG_W]),
    .pol_i   (op_i[POL_LSB +: FLAG_W]),
    .match_o (match)
  );

  pc_target_gen #(.ADDR_W(ADDR_W)) u_tgt (
    .cmd_i    (cmd_i),
    .match_i  (match),
    .pc_i     (pc_o),
    .imm_i    (imm_i),
    .pop_i    (pop_i),
    .active_o (active),
    .taken_o  (taken),
    .target_o (target)
  );

  pc_reg #(.ADDR_W(ADDR_W), .STEP(2)) u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (taken),
    .hold_i    (active),
    .adv_op_i  (fetch_op_i),
    .adv_imm_i (fetch_imm_i),
    .target_i  (target),
    .pc_o      (pc_o)
  );

  assign ret_addr_o = pc_o;
  assign taken_o    = taken;
endmodule

// File: rtl/pc_flow_unit_chk.sv
module pc_flow_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        fetch_op_i,
  input logic        fetch_imm_i,
  input logic [2:0]  cmd_i,
  input logic [15:0] imm_i,
  input logic [15:0] pop_i,
  input logic [15:0] pc_o,
  input logic        taken_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) a_r1_reset_pc: assert (pc_o == 16'h0000);
  end

  a_r4_jump_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1 && taken_o) |=> pc_o == $past(imm_i));

  a_r5_branch_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd2 && taken_o) |=> pc_o == 16'($past(pc_o) + $past(imm_i)));

  a_r6_not_taken_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_i == 3'd1 || cmd_i == 3'd2) && !taken_o) |=> $stable(pc_o));

  a_r8_return_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd5) |=> pc_o == $past(pop_i));

  a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd0 && (fetch_op_i ^ fetch_imm_i)) |=> pc_o == 16'($past(pc_o) + 16'd2));

  a_r10_idle_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd0 || cmd_i > 3'd5) |-> !taken_o);
endmodule

bind pc_flow_unit pc_flow_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fetch_op_i  (fetch_op_i),
  .fetch_imm_i (fetch_imm_i),
  .cmd_i       (cmd_i),
  .imm_i       (imm_i),
  .pop_i       (pop_i),
  .pc_o        (pc_o),
  .taken_o     (taken_o)
);

// File: tb/pc_flow_unit_tb.sv
`timescale 1ns/1ps
module pc_flow_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        f_op = 1'b0, f_imm = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [15:0] op = '0, imm = '0, pop = '0;
  logic [2:0]  flags = '0;
  logic [15:0] pc, ret_addr;
  logic        taken;

  int total = 0, bad = 0;
  bit finished = 0;
  int ref_pc = 0;

  always #10 clk = ~clk;

  pc_flow_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fetch_op_i(f_op), .fetch_imm_i(f_imm),
    .cmd_i(cmd), .op_i(op), .imm_i(imm), .flags_i(flags), .pop_i(pop),
    .pc_o(pc), .ret_addr_o(ret_addr), .taken_o(taken)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int c);
    case (c)
      1: return "R4/R6 jump";
      2: return "R5/R6 branch";
      3: return "R7 call_jump";
      4: return "R7 call_branch";
      5: return "R8 return";
      0: return "R2 fetch";
      default: return "R10 unused_cmd";
    endcase
  endfunction

  // One cycle: drive after falling edge, check comb outputs, check pc after next edge.
  task automatic step(input int c, input int o, input int im, input int fl,
                      input int pp, input bit fo, input bit fi);
    bit cond, exp_t;
    int nxt;
    cmd = 3'(c); op = 16'(o); imm = 16'(im); flags = 3'(fl);
    pop = 16'(pp); f_op = fo; f_imm = fi;
    cond = ((fl & ((o >> 3) & 7)) == (o & 7));
    case (c)
      1: begin exp_t = cond; nxt = cond ? im : ref_pc; end
      2: begin exp_t = cond; nxt = cond ? ref_pc + im : ref_pc; end
      3: begin exp_t = 1;    nxt = im; end
      4: begin exp_t = 1;    nxt = ref_pc + im; end
      5: begin exp_t = 1;    nxt = pp; end
      default: begin exp_t = 0; nxt = ref_pc + 2*fo + 2*fi; end
    endcase
    nxt &= 16'hFFFF;
    #3;
    chk(taken == exp_t, (c == 1 || c == 2) ? "R3 taken_cond" : "R10/R7/R8 taken", taken, exp_t);
    chk(ret_addr == 16'(ref_pc), "R7 ret_addr", ret_addr, ref_pc);
    ref_pc = nxt;
    @(negedge clk);
    chk(pc == 16'(ref_pc), (c >= 1 && c <= 5 && (fo || fi)) ? "R9 strobe_ignored" : tag_of(c),
        pc, ref_pc);
  endtask

  initial begin
    #5_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pc == 0, "R1 reset", pc, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pc == 0, "R1 after release", pc, 0);
    ref_pc = 0;

    step(0, 0, 0, 0, 0, 1, 0);           // R2 +2
    step(0, 0, 0, 0, 0, 0, 1);           // R2 +2
    step(0, 0, 0, 0, 0, 1, 1);           // R2 +4
    step(0, 0, 0, 0, 0, 0, 0);           // R2 hold
    step(1, 8'o00, 16'h1234, 0, 0, 0, 0);  // R4 always
    step(1, 8'o22, 16'h0100, 3'b000, 0, 0, 0); // zero set required: not taken R6
    step(1, 8'o22, 16'h0100, 3'b010, 0, 0, 0); // taken R4
    step(1, 8'o40, 16'h0500, 3'b100, 0, 0, 0); // carry clear required: not taken
    step(1, 8'o40, 16'h0500, 3'b011, 0, 0, 0); // taken
    step(2, 8'o00, 16'hFFFC, 0, 0, 0, 0);      // R5 backward
    step(2, 8'o11, 16'h0010, 3'b001, 0, 0, 0); // negative set: taken
    step(2, 8'o11, 16'h0010, 3'b000, 0, 1, 1); // not taken, R9 strobes ignored
    step(1, 8'o01, 16'h0700, 3'b111, 0, 0, 0); // care 0 pol 1: never
    step(1, 8'o00, 16'hFFF0, 0, 0, 0, 0);
    step(2, 8'o00, 16'h0020, 0, 0, 0, 0);      // R5 wrap
    step(3, 8'o77, 16'h2000, 3'b000, 0, 1, 0); // R7 ignores flags, R9
    step(4, 8'o77, 16'h0100, 3'b000, 0, 0, 0);
    step(5, 0, 0, 0, 16'h4442, 0, 1);          // R8, R9
    step(6, 0, 16'h9999, 0, 0, 1, 0);          // R10
    step(7, 0, 16'h9999, 0, 0, 1, 1);          // R10
    step(0, 0, 0, 0, 0, 1, 0);

    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 7), $urandom_range(0, 63), $urandom_range(0, 65535),
           $urandom_range(0, 7), $urandom_range(0, 65535),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

    // R1 asynchronous clear between edges
    #4 rst_n = 1'b0;
    #2 chk(pc == 0, "R1 async clear", pc, 0);
    @(negedge clk);
    rst_n = 1'b1; ref_pc = 0;
    step(0, 0, 0, 0, 0, 1, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule